// File: doc/BRIEF.md
# Processor Clock and Bus-Condition Generator

This block takes one oscillator (the module clock) and derives a processor clock that is high for one of every three source ticks and a peripheral clock at half the processor rate with an even duty cycle. The source of those ticks is chosen by a select input. With the select low, every oscillator cycle counts. With the select high, only the cycles on which an externally supplied frequency strobe is high count. The active source tick is also brought out directly.

The same block conditions the bus-ready input. It has two ready channels, each with its own active-low enable. The combined ready level is captured at each rising event of the processor clock, through either one or two register stages. It also turns an active-low reset request into an active-high processor reset. That reset changes only at falling events of the processor clock, so it is stable at every rising event where the processor samples it. A separate module reset puts the divider in a known phase.

Top module: `clkgen_core`

## Requirements
- R1: After the module reset is released, the processor clock output is high on source tick counts 0, 3, 6, … and low on every other count. It is therefore high for exactly one tick in three.
- R2: The peripheral clock output starts low and toggles at each rising event of the processor clock. Its level after n source ticks is (n/3) mod 2, which gives a period of six ticks, three high and three low.
- R3: With `ext_sel` = 0 the divider advances on every oscillator cycle and `osc_o` is 1. With `ext_sel` = 1 the divider advances only on cycles with `ext_tick` = 1, and `osc_o` equals `ext_tick`.
- R4: After the synchronizer has settled, `ready_o` is 1 exactly when at least one channel has its ready input at 1 and its active-low enable at 0. Otherwise it is 0.
- R5: With `two_stage` = 0, a change on the ready inputs appears on `ready_o` at the first rising event of the processor clock after the change, and not earlier.
- R6: With `two_stage` = 1, the change appears one processor clock period later than in R5, at the second rising event.
- R7: `reset_o` takes the inverse of `rst_req_n`, updated only at falling events of the processor clock. A falling event is the source tick that moves the phase from count 0 to count 1.
- R8: While `sys_rst_n` is 0, the outputs are as follows: processor clock 1 (phase 0), peripheral clock 0, `ready_o` 0 and `reset_o` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator; clock of all registers |
| sys_rst_n | input | 1 | Asynchronous module reset, active low |
| ext_sel | input | 1 | 1 selects the external frequency strobe as the tick source |
| ext_tick | input | 1 | External frequency strobe, synchronous to `osc_clk` |
| rdy_a | input | 1 | Ready input, channel A |
| aen_a_n | input | 1 | Channel A enable, active low |
| rdy_b | input | 1 | Ready input, channel B |
| aen_b_n | input | 1 | Channel B enable, active low |
| two_stage | input | 1 | 1 selects two synchronizer stages for ready |
| rst_req_n | input | 1 | Processor reset request, active low |
| clk_o | output | 1 | Processor clock, source divided by 3, one tick high |
| pclk_o | output | 1 | Peripheral clock, source divided by 6, even duty |
| osc_o | output | 1 | Active source tick |
| ready_o | output | 1 | Qualified, synchronized ready |
| reset_o | output | 1 | Processor reset, active high |

## Verification
The bench builds the block with its default divider, a divide-by-3 clock with one tick high. At that size, whole runs of many processor periods can be compared tick by tick against the arithmetic n mod 3 and (n/3) mod 2, under both the free-running source and an irregular external strobe. All sixteen combinations of the ready and enable inputs are swept under each stage setting. The one-stage and two-stage ready latencies and the falling-event update of the reset are each checked exactly, edge by edge, from a known phase.

// File: rtl/clkgen_core.sv
module clkgen_core #(
  parameter int DIV  = 3,
  parameter int HIGH = 1
) (
  input  logic osc_clk,
  input  logic sys_rst_n,
  input  logic ext_sel,
  input  logic ext_tick,
  input  logic rdy_a,
  input  logic aen_a_n,
  input  logic rdy_b,
  input  logic aen_b_n,
  input  logic two_stage,
  input  logic rst_req_n,
  output logic clk_o,
  output logic pclk_o,
  output logic osc_o,
  output logic ready_o,
  output logic reset_o
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] FALL = PW'(HIGH - 1);

  logic [PW-1:0] ph;
  logic tick, rise_ev, fall_ev, want;
  logic sy1, sy2, pclk_q, rst_q;

  assign tick    = ext_sel ? ext_tick : 1'b1;
  assign rise_ev = tick && (ph == LAST);
  assign fall_ev = tick && (ph == FALL);
  assign want    = (rdy_a & ~aen_a_n) | (rdy_b & ~aen_b_n);

  always_ff @(posedge osc_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      ph     <= '0;
      pclk_q <= 1'b0;
    end else if (tick) begin
      ph <= (ph == LAST) ? '0 : ph + 1'b1;
      if (ph == LAST) pclk_q <= ~pclk_q;
    end
  end

  always_ff @(posedge osc_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      sy1 <= 1'b0;
      sy2 <= 1'b0;
    end else if (rise_ev) begin
      sy1 <= want;
      sy2 <= sy1;
    end
  end

  always_ff @(posedge osc_clk or negedge sys_rst_n) begin
    if (!sys_rst_n)   rst_q <= 1'b1;
    else if (fall_ev) rst_q <= ~rst_req_n;
  end

  assign clk_o   = (ph < PW'(HIGH));
  assign pclk_o  = pclk_q;
  assign osc_o   = tick;
  assign ready_o = two_stage ? sy2 : sy1;
  assign reset_o = rst_q;
endmodule

// File: rtl/clkgen_core_chk.sv
module clkgen_core_chk (
  input logic osc_clk,
  input logic sys_rst_n,
  input logic ext_sel,
  input logic ext_tick,
  input logic two_stage,
  input logic rst_req_n,
  input logic clk_o,
  input logic pclk_o,
  input logic osc_o,
  input logic ready_o,
  input logic reset_o
);
  AST_CLK_HOLD: assert property (@(posedge osc_clk) disable iff (!sys_rst_n)
    !osc_o |=> ($stable(clk_o) && $stable(pclk_o))); // R3

  AST_OSC_EXT: assert property (@(posedge osc_clk) disable iff (!sys_rst_n)
    ext_sel |-> (osc_o == ext_tick)); // R3

  AST_PCLK_ON_RISE: assert property (@(posedge osc_clk) disable iff (!sys_rst_n)
    ($rose(pclk_o) || $fell(pclk_o)) |-> $rose(clk_o)); // R2

  AST_READY_ON_RISE: assert property (@(posedge osc_clk) disable iff (!sys_rst_n)
    (ready_o != $past(ready_o)) |-> ($rose(clk_o) || (two_stage != $past(two_stage)))); // R5

  AST_RESET_ON_FALL: assert property (@(posedge osc_clk) disable iff (!sys_rst_n)
    (reset_o != $past(reset_o)) |-> $fell(clk_o)); // R7

  AST_RESET_LEVEL: assert property (@(posedge osc_clk) disable iff (!sys_rst_n)
    $fell(clk_o) |-> (reset_o == !$past(rst_req_n))); // R7
endmodule

bind clkgen_core clkgen_core_chk u_chk (.*);

// File: tb/clkgen_core_bench.sv
module clkgen_core_bench;
  logic osc_clk = 1'b0;
  logic sys_rst_n, ext_sel, ext_tick, rdy_a, aen_a_n, rdy_b, aen_b_n;
  logic two_stage, rst_req_n;
  logic clk_o, pclk_o, osc_o, ready_o, reset_o;
  int errors = 0;
  int checks = 0;

  always #2 osc_clk = ~osc_clk;

  clkgen_core u_clkgen_core (.*);

  task automatic step(input int n);
    repeat (n) @(posedge osc_clk);
    @(negedge osc_clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic align();
    while (clk_o !== 1'b1) step(1);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    sys_rst_n = 0; ext_sel = 0; ext_tick = 0;
    rdy_a = 0; aen_a_n = 1; rdy_b = 0; aen_b_n = 1;
    two_stage = 0; rst_req_n = 0;
    step(3);
    chk(clk_o, 1'b1, "R8 clk");
    chk(pclk_o, 1'b0, "R8 pclk");
    chk(ready_o, 1'b0, "R8 ready");
    chk(reset_o, 1'b1, "R8 reset");

    sys_rst_n = 1;
    for (int k = 0; k < 60; k++) begin
      chk(clk_o, (k % 3) == 0, "R1 internal");
      chk(pclk_o, ((k / 3) % 2) == 1, "R2 internal");
      chk(osc_o, 1'b1, "R3 internal osc");
      step(1);
    end

    sys_rst_n = 0;
    step(1);
    ext_sel = 1;
    sys_rst_n = 1;
    n = 0;
    for (int i = 0; i < 90; i++) begin
      chk(clk_o, (n % 3) == 0, "R1 external");
      chk(pclk_o, ((n / 3) % 2) == 1, "R2 external");
      ext_tick = ((i * 7) % 5) < 2;
      #1;
      chk(osc_o, ext_tick, "R3 external osc");
      if (ext_tick) n++;
      step(1);
    end
    ext_sel = 0;
    ext_tick = 0;

    align();
    rst_req_n = 1;
    step(1);
    chk(reset_o, 1'b0, "R7 release");
    rst_req_n = 0;
    step(1);
    chk(reset_o, 1'b0, "R7 hold1");
    step(1);
    chk(reset_o, 1'b0, "R7 hold2");
    step(1);
    chk(reset_o, 1'b1, "R7 assert");
    rst_req_n = 1;

    for (int ts = 0; ts < 2; ts++) begin
      two_stage = ts[0];
      for (int c = 0; c < 16; c++) begin
        rdy_a = c[0]; aen_a_n = c[1]; rdy_b = c[2]; aen_b_n = c[3];
        step(9);
        chk(ready_o, (c[0] & ~c[1]) | (c[2] & ~c[3]), "R4 sweep");
      end
    end

    two_stage = 0;
    rdy_a = 0; aen_a_n = 0; rdy_b = 0; aen_b_n = 1;
    step(9);
    align();
    rdy_a = 1;
    step(2);
    chk(ready_o, 1'b0, "R5 early");
    step(1);
    chk(ready_o, 1'b1, "R5 latency");

    rdy_a = 0;
    step(9);
    two_stage = 1;
    step(1);
    align();
    rdy_a = 1;
    step(5);
    chk(ready_o, 1'b0, "R6 early");
    step(1);
    chk(ready_o, 1'b1, "R6 latency");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule